// File: doc/BRIEF.md
# Two-level short-descriptor address translation walker

The walker turns a 32-bit I/O virtual address into a 32-bit physical address by reading descriptors from a two-level page table kept in word-addressed memory. A client presents an address and an access type (read or write) while the walker is idle. The walker then fetches one first-level descriptor, and possibly one second-level descriptor, over a request/valid read port whose latency may vary. It ends every walk with a single-cycle done pulse that carries either a physical address or a fault cause.

Four mapping sizes are decoded. A first-level entry can map a 1 MB section or a 16 MB supersection, or it can point to a second-level table. A second-level entry can map a 4 KB small page or a 64 KB large page. A write to an entry marked read-only ends with a permission fault. The walker does no caching, so every request walks the table again from the base register.

Top module: `sd_walker`

## Requirements
- R1: While reset is high and in the first cycle after reset, req_ready is 1, and done, mem_rd_req, fault_code and phys_addr are all 0.
- R2: A request is taken only on a cycle where req_valid and req_ready are both high. req_ready is low from the cycle after acceptance until done. A request presented while the walker is busy is ignored: it causes no extra memory read and no extra done pulse.
- R3: The first read of a walk goes to the address {ttb_base[31:14], va[31:20], 2'b00}, so ttb_base[13:0] are ignored. Once mem_rd_req rises it stays high, with mem_rd_addr unchanged, until a cycle in which mem_rd_valid is high.
- R4: A first-level descriptor whose bits [1:0] are 00 ends the walk after one read, with fault_code 1 and phys_addr 0.
- R5: A first-level descriptor with bit 0 set is a table pointer. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 10 and bit 18 clear is a section. The result is {desc[31:20], va[19:0]}.
- R7: A first-level descriptor with bits [1:0] = 10 and bit 18 set is a supersection. The result is {desc[31:24], va[23:0]}.
- R8: A second-level descriptor with bit 1 set is a small page. The result is {desc[31:12], va[11:0]}.
- R9: A second-level descriptor with bits [1:0] = 01 is a large page. The result is {desc[31:16], va[15:0]}.
- R10: A second-level descriptor whose bits [1:0] are 00 gives fault_code 2 and phys_addr 0.
- R11: A write access (req_write = 1) gives fault_code 3 and phys_addr 0 in two cases: to a section or supersection with bit 15 set, and to a small or large page with bit 9 set. A read access through the same entry translates normally.
- R12: done is a one-cycle pulse in the cycle after the final read response is taken. fault_code is 0 on success. phys_addr and fault_code hold their values until the next done.
- R13: A second-level entry is never treated as a table pointer, so a walk makes at most two reads. A second-level descriptor with bits [1:0] = 01 ends the walk as a large page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Virtual address to translate |
| ttb_base | input | 32 | First-level table base; bits [13:0] are ignored |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_rd_req | output | 1 | Descriptor read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle walk completion pulse |
| phys_addr | output | 32 | Translated address, 0 on a fault |
| fault_code | output | 2 | 0 none, 1 level-1 translation, 2 level-2 translation, 3 permission |

## Verification
The assertions check the port protocol on every cycle:
- the read request stays high with a stable address until it is answered;
- no read is issued while the walker is idle;
- the first read address follows from the accepted request and the base register;
- done is a single pulse that always follows a read response;
- a faulted result carries a zero address.

Only the bench scenarios can show the decoding. They cover the output address for each mapping size, the address of the second read, the choice between the two translation faults and the permission fault, and the dropping of requests presented while busy. The bench compares each of these with an independent model that walks the bench's own table memory.

// File: rtl/sd_walk_pkg.sv
package sd_walk_pkg;

  // Address split and descriptor geometry
  localparam int SDW_ADDR_W   = 32;
  localparam int SDW_L1_IDX_W = 12;
  localparam int SDW_L2_IDX_W = 8;
  localparam int SDW_PAGE_W   = 12;
  localparam int SDW_WORD_LG  = 2;
  localparam int SDW_CONT_LG  = 4;

  // Derived bit positions
  localparam int SDW_SECT_SH  = SDW_L2_IDX_W + SDW_PAGE_W;
  localparam int SDW_L1_LSB   = SDW_SECT_SH;
  localparam int SDW_L2_LSB   = SDW_PAGE_W;
  localparam int SDW_TTB_LSB  = SDW_L1_IDX_W + SDW_WORD_LG;
  localparam int SDW_TBL_LSB  = SDW_L2_IDX_W + SDW_WORD_LG;

  // Descriptor flag positions
  localparam int SDW_SUPER_BIT = 18;
  localparam int SDW_L1_RO_BIT = 15;
  localparam int SDW_L2_RO_BIT = 9;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_XLAT_L1 = 2'd1,
    FLT_XLAT_L2 = 2'd2,
    FLT_PERM    = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_L1   = 2'd1,
    WS_L2   = 2'd2
  } wstate_e;

  typedef struct packed {
    logic                  descend;
    flt_e                  fault;
    logic [SDW_ADDR_W-1:0] pa;
  } step_res_t;

endpackage

// File: rtl/sd_entry_addr.sv
module sd_entry_addr
  import sd_walk_pkg::*;
#(
  parameter int IDX_LSB  = SDW_L1_LSB,
  parameter int IDX_W    = SDW_L1_IDX_W,
  parameter int BASE_LSB = SDW_TTB_LSB
) (
  input  logic [SDW_ADDR_W-1:0] base,
  input  logic [SDW_ADDR_W-1:0] va,
  output logic [SDW_ADDR_W-1:0] entry
);

  localparam logic [SDW_ADDR_W-1:0] ONE       = SDW_ADDR_W'(1);
  localparam logic [SDW_ADDR_W-1:0] BASE_MASK = ~((ONE << BASE_LSB) - ONE);
  localparam logic [SDW_ADDR_W-1:0] IDX_MASK  = (ONE << IDX_W) - ONE;

  logic [SDW_ADDR_W-1:0] idx;

  always_comb begin
    idx   = (va >> IDX_LSB) & IDX_MASK;
    entry = (base & BASE_MASK) | (idx << SDW_WORD_LG);
  end

endmodule

// File: rtl/sd_l1_step.sv
module sd_l1_step
  import sd_walk_pkg::*;
#(
  parameter int SECT_SH   = SDW_SECT_SH,
  parameter int CONT_LG   = SDW_CONT_LG,
  parameter int SUPER_BIT = SDW_SUPER_BIT,
  parameter int RO_BIT    = SDW_L1_RO_BIT
) (
  input  logic [SDW_ADDR_W-1:0] desc,
  input  logic [SDW_ADDR_W-1:0] va,
  input  logic                  is_write,
  output step_res_t             res
);

  localparam int SUPER_SH = SECT_SH + CONT_LG;
  localparam logic [SDW_ADDR_W-1:0] SECT_MASK  = {SDW_ADDR_W{1'b1}} << SECT_SH;
  localparam logic [SDW_ADDR_W-1:0] SUPER_MASK = {SDW_ADDR_W{1'b1}} << SUPER_SH;

  logic [SDW_ADDR_W-1:0] mask;

  always_comb begin
    mask = desc[SUPER_BIT] ? SUPER_MASK : SECT_MASK;
    res  = '0;
    if (desc[1:0] == 2'b00) begin
      res.fault = FLT_XLAT_L1;
    end else if (desc[0]) begin
      res.descend = 1'b1;
    end else if (is_write && desc[RO_BIT]) begin
      res.fault = FLT_PERM;
    end else begin
      res.pa = (desc & mask) | (va & ~mask);
    end
  end

endmodule

// File: rtl/sd_l2_step.sv
module sd_l2_step
  import sd_walk_pkg::*;
#(
  parameter int PAGE_SH = SDW_PAGE_W,
  parameter int CONT_LG = SDW_CONT_LG,
  parameter int RO_BIT  = SDW_L2_RO_BIT
) (
  input  logic [SDW_ADDR_W-1:0] desc,
  input  logic [SDW_ADDR_W-1:0] va,
  input  logic                  is_write,
  output step_res_t             res
);

  localparam int LARGE_SH = PAGE_SH + CONT_LG;
  localparam logic [SDW_ADDR_W-1:0] SMALL_MASK = {SDW_ADDR_W{1'b1}} << PAGE_SH;
  localparam logic [SDW_ADDR_W-1:0] LARGE_MASK = {SDW_ADDR_W{1'b1}} << LARGE_SH;

  logic [SDW_ADDR_W-1:0] mask;

  always_comb begin
    mask = desc[1] ? SMALL_MASK : LARGE_MASK;
    res  = '0;
    if (desc[1:0] == 2'b00) begin
      res.fault = FLT_XLAT_L2;
    end else if (is_write && desc[RO_BIT]) begin
      res.fault = FLT_PERM;
    end else begin
      res.pa = (desc & mask) | (va & ~mask);
    end
  end

endmodule

// File: rtl/sd_walker.sv
module sd_walker
  import sd_walk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [SDW_ADDR_W-1:0] req_addr,
  input  logic [SDW_ADDR_W-1:0] ttb_base,
  output logic                  req_ready,
  output logic                  mem_rd_req,
  output logic [SDW_ADDR_W-1:0] mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [SDW_ADDR_W-1:0] mem_rd_data,
  output logic                  done,
  output logic [SDW_ADDR_W-1:0] phys_addr,
  output logic [1:0]            fault_code
);

  wstate_e               state_q;
  logic [SDW_ADDR_W-1:0] va_q;
  logic                  wr_q;
  logic                  rd_req_q;
  logic [SDW_ADDR_W-1:0] rd_addr_q;
  logic                  done_q;
  logic [SDW_ADDR_W-1:0] pa_q;
  flt_e                  flt_q;

  logic [SDW_ADDR_W-1:0] l1_entry;
  logic [SDW_ADDR_W-1:0] l2_entry;
  step_res_t             l1_res;
  step_res_t             l2_res;

  // First-level entry address from the incoming request
  sd_entry_addr #(
    .IDX_LSB (SDW_L1_LSB),
    .IDX_W   (SDW_L1_IDX_W),
    .BASE_LSB(SDW_TTB_LSB)
  ) u_l1_addr (
    .base (ttb_base),
    .va   (req_addr),
    .entry(l1_entry)
  );

  // Second-level entry address from the returned table pointer
  sd_entry_addr #(
    .IDX_LSB (SDW_L2_LSB),
    .IDX_W   (SDW_L2_IDX_W),
    .BASE_LSB(SDW_TBL_LSB)
  ) u_l2_addr (
    .base (mem_rd_data),
    .va   (va_q),
    .entry(l2_entry)
  );

  sd_l1_step u_l1_step (
    .desc    (mem_rd_data),
    .va      (va_q),
    .is_write(wr_q),
    .res     (l1_res)
  );

  sd_l2_step u_l2_step (
    .desc    (mem_rd_data),
    .va      (va_q),
    .is_write(wr_q),
    .res     (l2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WS_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      done_q    <= 1'b0;
      pa_q      <= '0;
      flt_q     <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            va_q      <= req_addr;
            wr_q      <= req_write;
            rd_addr_q <= l1_entry;
            rd_req_q  <= 1'b1;
            state_q   <= WS_L1;
          end
        end
        WS_L1: begin
          if (mem_rd_valid) begin
            if (l1_res.descend) begin
              rd_addr_q <= l2_entry;
              state_q   <= WS_L2;
            end else begin
              rd_req_q <= 1'b0;
              done_q   <= 1'b1;
              pa_q     <= l1_res.pa;
              flt_q    <= l1_res.fault;
              state_q  <= WS_IDLE;
            end
          end
        end
        WS_L2: begin
          if (mem_rd_valid) begin
            rd_req_q <= 1'b0;
            done_q   <= 1'b1;
            pa_q     <= l2_res.pa;
            flt_q    <= l2_res.fault;
            state_q  <= WS_IDLE;
          end
        end
        default: begin
          rd_req_q <= 1'b0;
          state_q  <= WS_IDLE;
        end
      endcase
    end
  end

  assign req_ready   = (state_q == WS_IDLE);
  assign mem_rd_req  = rd_req_q;
  assign mem_rd_addr = rd_addr_q;
  assign done        = done_q;
  assign phys_addr   = pa_q;
  assign fault_code  = flt_q;

endmodule

// File: rtl/sd_walker_chk.sv
module sd_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [31:0] ttb_base,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        done,
  input logic [31:0] phys_addr,
  input logic [1:0]  fault_code
);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R3
  first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (mem_rd_req && !req_ready &&
       mem_rd_addr[31:14] == $past(ttb_base[31:14]) &&
       mem_rd_addr[13:2]  == $past(req_addr[31:20]) &&
       mem_rd_addr[1:0]   == 2'b00));

  // R2
  idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_req);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_after_resp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_rd_valid));

  // R4
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != 2'd0) |-> (phys_addr == 32'h0));

endmodule

bind sd_walker sd_walker_chk u_chk (.*);

// File: tb/sd_walker_tb.sv
`timescale 1ns/100ps
module sd_walker_tb;

  localparam logic [31:0] TTB = 32'h8004_3ABC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] ttb_base = TTB;
  logic        req_ready;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        done;
  logic [31:0] phys_addr;
  logic [1:0]  fault_code;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [31:0] mem [logic [31:0]];
  int          rd_cnt;
  logic [31:0] rd_log [4];
  bit          hold_bad;

  always #2.5 clk = ~clk;

  sd_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .ttb_base(ttb_base), .req_ready(req_ready),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .phys_addr(phys_addr), .fault_code(fault_code)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference walk over the bench memory
  task automatic model(input logic [31:0] va, input bit wr,
                       output logic [31:0] pa, output logic [1:0] flt,
                       output int nrd, output logic [31:0] a1,
                       output logic [31:0] a2, output string tag);
    logic [31:0] d1, d2;
    pa = 0; flt = 0; a2 = 0;
    a1 = {TTB[31:14], va[31:20], 2'b00};
    d1 = rd(a1); nrd = 1;
    if (d1[1:0] == 2'b00) begin
      flt = 2'd1; tag = "R4";
    end else if (d1[0]) begin
      a2 = {d1[31:10], va[19:12], 2'b00};
      d2 = rd(a2); nrd = 2;
      if (d2[1:0] == 2'b00) begin
        flt = 2'd2; tag = "R10";
      end else if (wr && d2[9]) begin
        flt = 2'd3; tag = "R11";
      end else if (d2[1]) begin
        pa = {d2[31:12], va[11:0]}; tag = "R8";
      end else begin
        pa = {d2[31:16], va[15:0]}; tag = "R9";
      end
    end else if (wr && d1[15]) begin
      flt = 2'd3; tag = "R11";
    end else if (d1[18]) begin
      pa = {d1[31:24], va[23:0]}; tag = "R7";
    end else begin
      pa = {d1[31:20], va[19:0]}; tag = "R6";
    end
  endtask

  // Memory responder with random latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (!rst && mem_rd_req) begin
        logic [31:0] a;
        int lat;
        a = mem_rd_addr;
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        lat = $urandom % 4;
        repeat (lat) begin
          @(negedge clk);
          if (!mem_rd_req || mem_rd_addr != a) hold_bad = 1;
        end
        mem_rd_data  = rd(a);
        mem_rd_valid = 1'b1;
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input bit wr);
    logic [31:0] pa, a1, a2, pa_seen;
    logic [1:0]  flt;
    int nrd, cyc;
    string tag;
    model(va, wr, pa, flt, nrd, a1, a2, tag);
    rd_cnt = 0; hold_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low while busy", 32'(req_ready), 0);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R12", "done seen", 32'(done), 1);
    chk(phys_addr == pa, tag, "phys_addr", phys_addr, pa);
    chk(fault_code == flt, tag, "fault_code", 32'(fault_code), 32'(flt));
    chk(rd_cnt == nrd, "R13", "read count", rd_cnt, nrd);
    chk(rd_log[0] == a1, "R3", "first read addr", rd_log[0], a1);
    if (nrd == 2) chk(rd_log[1] == a2, "R5", "second read addr", rd_log[1], a2);
    chk(!hold_bad, "R3", "request held stable", 32'(hold_bad), 0);
    pa_seen = phys_addr;
    @(negedge clk);
    chk(!done, "R12", "done is one cycle", 32'(done), 0);
    chk(phys_addr == pa_seen, "R12", "phys_addr holds", phys_addr, pa_seen);
  endtask

  function automatic logic [31:0] l1a(input logic [31:0] va);
    return {TTB[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [31:0] l2a(input logic [31:0] d1, input logic [31:0] va);
    return {d1[31:10], va[19:12], 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, d1, d2, pa_exp;
    void'($urandom(32'd20240611));
    rd_cnt = 0; hold_bad = 0;
    repeat (4) @(negedge clk);
    chk(req_ready && !done && !mem_rd_req && fault_code == 0 && phys_addr == 0,
        "R1", "state during reset", {req_ready, done, mem_rd_req, fault_code}, 32'h10);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !mem_rd_req && fault_code == 0 && phys_addr == 0,
        "R1", "state after reset", {req_ready, done, mem_rd_req, fault_code}, 32'h10);

    // R6 section
    va = 32'h1234_5678; mem[l1a(va)] = 32'hABC0_0002; run_walk(va, 0);
    // R7 supersection
    va = 32'h5566_7788; mem[l1a(va)] = 32'hDE04_0002; run_walk(va, 0);
    // R4 invalid first level
    va = 32'h0000_002A; mem[l1a(va)] = 32'hFFFF_FFFC; run_walk(va, 0);
    // R5 R8 small page
    va = 32'h4010_3456; d1 = 32'h0123_4401; mem[l1a(va)] = d1;
    mem[l2a(d1, va)] = 32'h7654_3002; run_walk(va, 0);
    // R9 R13 large page with low bits 01
    va = 32'h4012_9ABC; mem[l2a(d1, va)] = 32'h89AB_0001; run_walk(va, 1);
    // R10 invalid second level
    va = 32'h4013_0000; mem[l2a(d1, va)] = 32'h0000_0000; run_walk(va, 0);
    // R11 read-only section: write faults, read passes
    va = 32'h9000_0ABC; mem[l1a(va)] = 32'h9100_8002;
    run_walk(va, 1); run_walk(va, 0);
    // R11 read-only small page
    va = 32'h4014_0010; mem[l2a(d1, va)] = 32'h3333_3202;
    run_walk(va, 1); run_walk(va, 0);

    // R2 request while busy is ignored
    va = 32'h4015_0123; mem[l2a(d1, va)] = 32'h2222_2002;
    pa_exp = {20'h22222, va[11:0]};
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = 1'b0;
    @(negedge clk);
    req_addr = 32'h1234_5678;
    while (!done) begin
      chk(!req_ready, "R2", "ready low while busy", 32'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(phys_addr == pa_exp, "R2", "first request result", phys_addr, pa_exp);
    repeat (8) @(negedge clk);
    chk(rd_cnt == 2, "R2", "no read from ignored request", rd_cnt, 2);
    chk(!done && phys_addr == pa_exp, "R2", "no extra completion", phys_addr, pa_exp);

    // Random walks
    for (int n = 0; n < 300; n++) begin
      int k;
      va = $urandom;
      d1 = $urandom;
      k = $urandom % 4;
      case (k)
        0: d1[1:0] = 2'b00;
        1: d1[1:0] = 2'b10;
        default: d1[0] = 1'b1;
      endcase
      mem[l1a(va)] = d1;
      if (d1[0]) begin
        d2 = $urandom;
        k = $urandom % 3;
        case (k)
          0: d2[1:0] = 2'b00;
          1: d2[1] = 1'b1;
          default: d2[1:0] = 2'b01;
        endcase
        mem[l2a(d1, va)] = d2;
      end
      run_walk(va, 1'($urandom % 2));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule